// File: doc/BRIEF.md
# Speculative Line Write Buffer

This block holds the stores of one speculative thread until that thread becomes safe. Each store comes in from the write bus as one word of up to eight bytes with per-byte enables. The buffer groups stores by cache line. Every entry keeps a line tag, a full 64-byte line image and a 64-bit byte mask. An associative compare across all valid entries finds the line of an incoming store. A hit merges the enabled bytes into that entry. A miss claims the next free slot at the tail.

When the thread commits, the buffer enters a drain mode. It then offers its lines one at a time, oldest first, on a valid/ready port toward the second-level cache. Each offered line carries its base address, the line data and the byte mask, so the cache updates only the bytes the thread wrote. When the thread is squashed, a discard strobe empties the whole buffer in one cycle. A store that cannot be taken raises a stall flag so the processor can be held. This happens when the store misses on a full buffer, or when it arrives during a drain.

Top module: `swb_line_buffer`

## Requirements
- R1: While reset is held and right after it, the buffer is empty: `l2_valid` is 0, and `st_stall` is 0 even when `st_valid` is 1.
- R2: A store whose line (address bits [31:6]) matches no valid entry allocates a new entry. In that entry, byte `w*8+i` of the line takes data byte i, where w is address bits [5:3], for each set bit i of `st_be`, and the matching mask bits are set. Bytes that no store enabled read as zero with a clear mask bit.
- R3: A store whose line matches a valid entry allocates nothing. It overwrites only the bytes it enables and ORs its byte enables into that entry's mask, leaving earlier mask bits set.
- R4: When all 16 entries are valid, a store that misses drives `st_stall` high in the same cycle and is dropped. A store that hits is still accepted with `st_stall` low.
- R5: After a `commit` pulse on a non-empty buffer, every entry is presented exactly once on the drain port, in allocation order. `l2_addr` is the line base address (low 6 bits zero). `l2_valid` falls once the last line is accepted.
- R6: While `l2_valid` is high and `l2_ready` is low, the presented address, data and mask stay unchanged and `l2_valid` stays high.
- R7: From the commit until the last line is accepted, every store sees `st_stall` high and is dropped. After the drain, stores are accepted again into an empty buffer.
- R8: A `discard` pulse empties the buffer in one cycle. A later commit drains nothing, and a store to a previously held line starts a fresh mask. Discard takes precedence over a `commit` in the same cycle.
- R9: A `commit` on an empty buffer starts no drain: `l2_valid` stays 0 and the next store is not stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store present on the write bus |
| st_addr | input | 32 | Byte address of the store word (bits [2:0] ignored) |
| st_data | input | 64 | Store word, byte i in bits [8i+7:8i] |
| st_be | input | 8 | Byte enables of the store word |
| st_stall | output | 1 | Store cannot be taken this cycle |
| commit | input | 1 | Thread has become non-speculative; start draining |
| discard | input | 1 | Thread was squashed; empty the buffer |
| l2_valid | output | 1 | A committed line is offered to the cache |
| l2_ready | input | 1 | Cache accepts the offered line |
| l2_addr | output | 32 | Base byte address of the offered line |
| l2_data | output | 512 | Line image, byte b in bits [8b+7:8b] |
| l2_mask | output | 64 | Byte mask of the offered line |

## Verification
The hardest case to reach is the one where a full buffer still accepts a hitting store while rejecting a missing one. The stimulus first fills all sixteen slots with distinct lines and then sends one miss and one hit. The drain that follows shows that the miss left no trace and that the hit merged into its line. A second hard case is a stall offered while the drain is in progress. To reach it, the bench keeps `l2_ready` low right after the commit so the drain cannot finish, offers the store, and then drains with an irregular ready pattern that also exercises the hold rule.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic {
    SWB_SPEC  = 1'b0,
    SWB_DRAIN = 1'b1
  } swb_mode_e;
endpackage

// File: rtl/swb_cam.sv
module swb_cam #(
  parameter int NUM_ENTRIES = 16,
  parameter int TAG_W       = 26
) (
  input  logic [NUM_ENTRIES-1:0]            valid_vec,
  input  logic [NUM_ENTRIES-1:0][TAG_W-1:0] tag_vec,
  input  logic [TAG_W-1:0]                  key,
  output logic [NUM_ENTRIES-1:0]            hit_vec,
  output logic                              hit
);
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = valid_vec[i] && (tag_vec[i] == key);
  end
  assign hit = |hit_vec;
endmodule

// File: rtl/swb_entry.sv
module swb_entry #(
  parameter int LINE_BYTES  = 64,
  parameter int STORE_BYTES = 8,
  parameter int TAG_W       = 26,
  localparam int WIDX_W     = $clog2(LINE_BYTES / STORE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_all,
  input  logic                    alloc,
  input  logic                    merge,
  input  logic                    drop,
  input  logic [TAG_W-1:0]        tag_in,
  input  logic [WIDX_W-1:0]       widx,
  input  logic [STORE_BYTES*8-1:0] wdata,
  input  logic [STORE_BYTES-1:0]  wbe,
  output logic                    valid_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic [LINE_BYTES*8-1:0] data_o,
  output logic [LINE_BYTES-1:0]   mask_o
);
  logic                  valid_q, valid_d;
  logic [TAG_W-1:0]      tag_q;
  logic [LINE_BYTES-1:0] mask_q, mask_d, lane_mask;
  logic [7:0]            data_q [LINE_BYTES];
  logic [7:0]            data_d [LINE_BYTES];
  logic                  wr_en;

  assign wr_en = (alloc || merge) && !clr_all;

  always_comb begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      lane_mask[b] = (widx == WIDX_W'(b / STORE_BYTES)) && wbe[b % STORE_BYTES];
    end
  end

  always_comb begin
    valid_d = valid_q;
    mask_d  = mask_q;
    if (clr_all || drop) begin
      valid_d = 1'b0;
    end else if (alloc) begin
      valid_d = 1'b1;
      mask_d  = lane_mask;
    end else if (merge) begin
      mask_d  = mask_q | lane_mask;
    end
  end

  always_comb begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (lane_mask[b]) begin
        data_d[b] = wdata[(b % STORE_BYTES)*8 +: 8];
      end else if (alloc) begin
        data_d[b] = 8'h00;
      end else begin
        data_d[b] = data_q[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      valid_q <= valid_d;
      mask_q  <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && alloc) begin
      tag_q <= tag_in;
    end
    if (wr_en) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        data_q[b] <= data_d[b];
      end
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign mask_o  = mask_q;
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_out
    assign data_o[b*8 +: 8] = data_q[b];
  end

  // R3: a merge never clears a mask bit that was already set
  a_r3_mask_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && merge && !clr_all && !drop) |=> ((mask_q & $past(mask_q)) == $past(mask_q)));

  // R2: an allocation leaves the entry valid
  a_r2_alloc_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !clr_all) |=> valid_q);
endmodule

// File: rtl/swb_ctrl.sv
module swb_ctrl
  import swb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int PTR_W      = $clog2(NUM_ENTRIES),
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic             hit,
  input  logic             commit,
  input  logic             discard,
  input  logic             drain_fire,
  output logic             st_stall,
  output logic             do_alloc,
  output logic             do_merge,
  output logic             draining,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail
);
  swb_mode_e        mode_q, mode_d;
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             full, take;

  assign full     = (count_q == CNT_W'(NUM_ENTRIES));
  assign draining = (mode_q == SWB_DRAIN);
  assign st_stall = st_valid && (draining || (!hit && full));
  assign take     = st_valid && !st_stall && !discard;
  assign do_alloc = take && !hit;
  assign do_merge = take && hit;

  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    count_d = count_q;
    mode_d  = mode_q;
    if (discard) begin
      head_d  = '0;
      tail_d  = '0;
      count_d = '0;
      mode_d  = SWB_SPEC;
    end else begin
      if (do_alloc) begin
        tail_d  = (tail_q == PTR_W'(NUM_ENTRIES - 1)) ? '0 : tail_q + 1'b1;
        count_d = count_q + 1'b1;
      end
      if (drain_fire) begin
        head_d  = (head_q == PTR_W'(NUM_ENTRIES - 1)) ? '0 : head_q + 1'b1;
        count_d = count_q - 1'b1;
      end
      if (mode_q == SWB_SPEC) begin
        if (commit && (count_d != '0)) mode_d = SWB_DRAIN;
      end else if (count_d == '0) begin
        mode_d = SWB_SPEC;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      mode_q  <= SWB_SPEC;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
      mode_q  <= mode_d;
    end
  end

  assign head = head_q;
  assign tail = tail_q;

  // R4: occupancy never exceeds the entry count
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(NUM_ENTRIES));

  // R4: a stalled store leaves occupancy unchanged
  a_r4_stall_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (st_stall && !drain_fire && !discard) |=> (count_q == $past(count_q)));

  // R8: discard empties in one cycle
  a_r8_discard_empty: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> (count_q == '0 && mode_q == SWB_SPEC));

  // R9: commit on an empty buffer never enters drain
  a_r9_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SWB_SPEC && commit && count_q == '0 && !st_valid) |=> (mode_q == SWB_SPEC));
endmodule

// File: rtl/swb_line_buffer.sv
module swb_line_buffer #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int STORE_BYTES = 8,
  parameter int NUM_ENTRIES = 16,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int SOFF_W     = $clog2(STORE_BYTES),
  localparam int TAG_W      = ADDR_W - OFF_W,
  localparam int PTR_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     st_valid,
  input  logic [ADDR_W-1:0]        st_addr,
  input  logic [STORE_BYTES*8-1:0] st_data,
  input  logic [STORE_BYTES-1:0]   st_be,
  output logic                     st_stall,
  input  logic                     commit,
  input  logic                     discard,
  output logic                     l2_valid,
  input  logic                     l2_ready,
  output logic [ADDR_W-1:0]        l2_addr,
  output logic [LINE_BYTES*8-1:0]  l2_data,
  output logic [LINE_BYTES-1:0]    l2_mask
);
  logic [NUM_ENTRIES-1:0]                   ent_valid, hit_vec;
  logic [NUM_ENTRIES-1:0][TAG_W-1:0]        ent_tag;
  logic [NUM_ENTRIES-1:0][LINE_BYTES*8-1:0] ent_data;
  logic [NUM_ENTRIES-1:0][LINE_BYTES-1:0]   ent_mask;
  logic [TAG_W-1:0]       key;
  logic                   hit, do_alloc, do_merge, draining, drain_fire;
  logic [PTR_W-1:0]       head, tail;
  logic                   unused_lo;

  assign key       = st_addr[ADDR_W-1:OFF_W];
  assign unused_lo = ^st_addr[SOFF_W-1:0];

  swb_cam #(.NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W)) u_cam (
    .valid_vec(ent_valid), .tag_vec(ent_tag), .key(key),
    .hit_vec(hit_vec), .hit(hit)
  );

  swb_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .hit(hit),
    .commit(commit), .discard(discard), .drain_fire(drain_fire),
    .st_stall(st_stall), .do_alloc(do_alloc), .do_merge(do_merge),
    .draining(draining), .head(head), .tail(tail)
  );

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    swb_entry #(.LINE_BYTES(LINE_BYTES), .STORE_BYTES(STORE_BYTES), .TAG_W(TAG_W)) u_entry (
      .clk(clk), .rst_n(rst_n), .clr_all(discard),
      .alloc(do_alloc && (tail == PTR_W'(i))),
      .merge(do_merge && hit_vec[i]),
      .drop(drain_fire && (head == PTR_W'(i))),
      .tag_in(key), .widx(st_addr[OFF_W-1:SOFF_W]),
      .wdata(st_data), .wbe(st_be),
      .valid_o(ent_valid[i]), .tag_o(ent_tag[i]),
      .data_o(ent_data[i]), .mask_o(ent_mask[i])
    );
  end

  assign l2_valid   = draining && ent_valid[head];
  assign drain_fire = l2_valid && l2_ready && !discard;
  assign l2_addr    = {ent_tag[head], {OFF_W{1'b0}}};
  assign l2_data    = ent_data[head];
  assign l2_mask    = ent_mask[head];

  // R3: at most one entry holds any line
  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R6: an offered line holds until accepted
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_valid && !l2_ready && !discard) |=>
      (l2_valid && $stable(l2_addr) && $stable(l2_mask) && $stable(l2_data)));
endmodule

// File: tb/swb_line_buffer_tb.sv
module swb_line_buffer_tb;
  localparam int N  = 16;
  localparam int LB = 64;

  typedef struct packed {
    logic [31:0] addr;
    logic [63:0] data;
    logic [7:0]  be;
    logic        stall;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{32'h0000_1000, 64'h1716_1514_1312_1110, 8'hFF, 1'b0},
    '{32'h0000_2048, 64'h2726_2524_2322_2120, 8'h0F, 1'b0},
    '{32'h0000_1038, 64'h3736_3534_3332_3130, 8'hF0, 1'b0},
    '{32'h0000_30C0, 64'h4746_4544_4342_4140, 8'h01, 1'b0},
    '{32'h0000_2048, 64'h5756_5554_5352_5150, 8'h3C, 1'b0},
    '{32'h0000_1000, 64'h6766_6564_6362_6160, 8'h81, 1'b0},
    '{32'h0000_4010, 64'h7776_7574_7372_7170, 8'hFF, 1'b0},
    '{32'h0000_30F8, 64'h8786_8584_8382_8180, 8'h80, 1'b0}
  };

  logic         clk, rst_n;
  logic         st_valid, st_stall, commit, discard;
  logic [31:0]  st_addr;
  logic [63:0]  st_data;
  logic [7:0]   st_be;
  logic         l2_valid, l2_ready;
  logic [31:0]  l2_addr;
  logic [511:0] l2_data;
  logic [63:0]  l2_mask;

  int checks = 0;
  int fails  = 0;

  logic [25:0] m_tag  [N];
  logic [7:0]  m_data [N][LB];
  logic [63:0] m_mask [N];
  int          m_n    = 0;
  bit          m_drain = 0;

  swb_line_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be), .st_stall(st_stall),
    .commit(commit), .discard(discard), .l2_valid(l2_valid),
    .l2_ready(l2_ready), .l2_addr(l2_addr), .l2_data(l2_data), .l2_mask(l2_mask)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_store(input logic [31:0] a, input logic [63:0] d,
                          input logic [7:0] be, input string req);
    int  hit_k = -1;
    bit  exp_stall;
    int  k;
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    for (int j = 0; j < m_n; j++) if (m_tag[j] == a[31:6]) hit_k = j;
    exp_stall = m_drain || (hit_k < 0 && m_n == N);
    #1;
    chk(st_stall == exp_stall, req, "st_stall", 512'(st_stall), 512'(exp_stall));
    if (!exp_stall) begin
      k = hit_k;
      if (k < 0) begin
        k = m_n; m_n++;
        m_tag[k] = a[31:6]; m_mask[k] = '0;
        for (int b = 0; b < LB; b++) m_data[k][b] = 8'h00;
      end
      for (int i = 0; i < 8; i++) begin
        if (be[i]) begin
          m_data[k][a[5:3]*8 + i] = d[i*8 +: 8];
          m_mask[k][a[5:3]*8 + i] = 1'b1;
        end
      end
    end
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic pulse(input bit c, input bit d);
    @(negedge clk);
    commit = c; discard = d;
    @(posedge clk); #1;
    commit = 1'b0; discard = 1'b0;
    if (d) begin m_n = 0; m_drain = 0; end
    else if (c && m_n > 0) m_drain = 1;
  endtask

  task automatic drain_all(input bit slow, input string req);
    int got = 0;
    int cyc = 0;
    bit held = 0;
    bit rdy;
    logic [31:0]  held_addr;
    logic [511:0] exp_d;
    while (got < m_n && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (held) chk(l2_valid && l2_addr == held_addr, "R6", "held addr",
                    512'(l2_addr), 512'(held_addr));
      held = 0;
      rdy = slow ? (cyc % 3 != 1) : 1'b1;
      l2_ready = rdy;
      if (l2_valid) begin
        if (rdy) begin
          for (int b = 0; b < LB; b++) exp_d[b*8 +: 8] = m_data[got][b];
          chk(l2_addr == {m_tag[got], 6'b0}, req, "l2_addr", 512'(l2_addr), 512'({m_tag[got], 6'b0}));
          chk(l2_mask == m_mask[got], req, "l2_mask", 512'(l2_mask), 512'(m_mask[got]));
          chk(l2_data == exp_d, req, "l2_data", l2_data, exp_d);
          got++;
        end else begin
          held = 1; held_addr = l2_addr;
        end
      end
    end
    chk(got == m_n, "R5", "beats", 512'(got), 512'(m_n));
    @(negedge clk);
    l2_ready = 1'b0;
    chk(!l2_valid, "R5", "valid after drain", 512'(l2_valid), 512'(0));
    m_n = 0; m_drain = 0;
  endtask

  task automatic quiet(input int cycles, input string req);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      l2_ready = 1'b1;
      chk(!l2_valid, req, "no drain", 512'(l2_valid), 512'(0));
    end
    l2_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b1; st_addr = '0; st_data = '0; st_be = '0;
    commit = 1'b0; discard = 1'b0; l2_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!l2_valid, "R1", "l2_valid in reset", 512'(l2_valid), 512'(0));
    chk(!st_stall, "R1", "st_stall in reset", 512'(st_stall), 512'(0));
    rst_n = 1'b1; st_valid = 1'b0; l2_ready = 1'b0;
    @(negedge clk);
    chk(!l2_valid, "R1", "l2_valid after reset", 512'(l2_valid), 512'(0));

    // R2 R3: table of stores with allocations and merges, then commit (R5)
    foreach (VEC[v]) begin
      do_store(VEC[v].addr, VEC[v].data, VEC[v].be, VEC[v].stall ? "R4" : "R2");
    end
    chk(m_n == 4, "R3", "bench lines", 512'(m_n), 512'(4));
    pulse(1'b1, 1'b0);
    drain_all(1'b0, "R5");

    // R4: fill all entries, then a miss stalls and a hit merges
    for (int k = 0; k < N; k++) begin
      do_store(32'h0001_0000 + 32'(k * 64) + 32'((k % 8) * 8), {8{8'(k + 8'hA0)}},
               8'(1 << (k % 8)), "R2");
    end
    do_store(32'h0002_0000, 64'hDEAD_BEEF_0BAD_F00D, 8'hFF, "R4");
    do_store(32'h0001_0140, 64'h0C0B_0A09_0807_0605, 8'hF0, "R4");
    pulse(1'b1, 1'b0);
    l2_ready = 1'b0;
    do_store(32'h0001_0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R7");
    drain_all(1'b1, "R6");
    do_store(32'h0000_5000, 64'h1234_5678_9ABC_DEF0, 8'h0F, "R7");

    // R8: discard empties, commit drains nothing
    do_store(32'h0000_6000, 64'h1, 8'h01, "R2");
    do_store(32'h0000_1000, 64'hAA, 8'h01, "R2");
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    quiet(4, "R8");
    do_store(32'h0000_1000, 64'h0000_0000_0000_BB00, 8'h02, "R8");
    pulse(1'b1, 1'b1);
    quiet(4, "R8");
    do_store(32'h0000_1000, 64'h0000_0000_00CC_0000, 8'h04, "R8");
    pulse(1'b1, 1'b0);
    drain_all(1'b0, "R8");

    // R9: commit with nothing held
    pulse(1'b1, 1'b0);
    quiet(3, "R9");
    do_store(32'h0000_7008, 64'h0, 8'h80, "R9");
    pulse(1'b1, 1'b0);
    drain_all(1'b0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule